// File: doc/BRIEF.md
# Video Controller Status Word and Write-Queue Model

This block assembles the 16-bit status word that a video controller returns to its host processor, and it models the small write queue that sits between the host and video memory. The queue is not backed by storage. It is an occupancy counter that rises by one on each host data write made during active display. It falls by one entry per drain period, and the length of that period depends on the line-width mode and on whether the write target is video RAM.

When the host writes into a queue that is already full, the block raises a stall request. The request holds until the next drain frees a slot, and the held write then takes that slot. The remaining status bits come from several places. Some are taken live from the inputs: region, DMA activity, field parity and the vertical interrupt. Two are derived: horizontal blanking from the position within the line, and vertical blanking from the blanking input and the display enable. Two are sticky sprite event flags that a status read clears.

Top module: `vid_status_fifo`

## Requirements
- R1: After reset, with the display enabled, vertical blank low and the line position at 588 or above, the status word equals 0x0200 OR'd with the region input in bit 0. In that state fifoFull is 0, fifoEmpty is 1 and cpuStall is 0.
- R2: Status bit 0 follows palMode, bit 1 follows dmaBusy, bit 4 follows oddField and bit 7 follows vintPending in the same cycle. Bits 15 to 10 always read 0.
- R3: Status bit 2 (horizontal blank) reads 1 exactly when linePos is below 588. The line is 3420 cycles long.
- R4: Status bit 3 (vertical blank) reads 1 when vblank is high or dispEnable is low.
- R5: A dataWr pulse during active display (dispEnable high, vblank low) adds one queue entry at that clock edge. It clears fifoEmpty and status bit 9 from the next cycle on.
- R6: A dataWr pulse while vblank is high or dispEnable is low leaves the queue occupancy unchanged.
- R7: fifoFull and status bit 8 are 1 while the queue holds 4 entries.
- R8: The queue drains one entry per period. The period is 190 cycles in wide mode and 214 cycles in narrow mode, and it is doubled when vramTarget is high. An entry accepted into an empty queue at edge e leaves at edge e+period.
- R9: fifoFull clears once occupancy drops below 4. fifoEmpty and status bit 9 set when occupancy reaches 0.
- R10: An active-display write into a full queue raises cpuStall from the next cycle until the next drain edge. At that edge the held write takes the freed slot, so the queue stays full and cpuStall falls.
- R11: The drain timer runs continuously while the queue is non-empty. A write to a non-empty queue does not restart it, so the cycles left over in the current period still count.
- R12: Status bits 5 and 6 are set by pulses on sprCollision and sprOverflow and hold until a status read. They read 0 from the cycle after a statusRd that had no new event in the same cycle. An event in the read cycle keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| palMode | input | 1 | Region flag, shown in status bit 0 |
| dmaBusy | input | 1 | DMA activity, shown in status bit 1 |
| oddField | input | 1 | Interlace field parity, shown in status bit 4 |
| vintPending | input | 1 | Vertical interrupt pending, shown in status bit 7 |
| dispEnable | input | 1 | Display enable |
| vblank | input | 1 | Vertical blanking interval |
| wideMode | input | 1 | 1 selects wide lines (190-cycle period), 0 selects narrow lines (214) |
| vramTarget | input | 1 | Current write target is video RAM (doubles the period) |
| linePos | input | 12 | Cycle position within the 3420-cycle line |
| sprCollision | input | 1 | Sprite collision event pulse |
| sprOverflow | input | 1 | Sprite overflow event pulse |
| dataWr | input | 1 | Host data write strobe, one cycle per write |
| statusRd | input | 1 | Host status read strobe |
| statusWord | output | 16 | Assembled status word |
| fifoFull | output | 1 | Queue holds 4 entries |
| fifoEmpty | output | 1 | Queue holds no entries |
| cpuStall | output | 1 | Host must hold off until the next drain |

## Verification
The status fields taken from the inputs are combinational, so they are checked in the same cycle as the input change. Queue flags change at the clock edge that takes the write, and they are sampled at the following falling edge. A drain falls exactly one period of edges after the entry arrived. The bench therefore samples one falling edge before that edge and one falling edge after it, so a period that is off by one cycle in either direction fails. The stall is bracketed the same way around its release drain. The sticky flags are sampled during the read cycle and in the cycle that follows it.

// File: rtl/vid_status_pkg.sv
package vid_status_pkg;
  typedef struct packed {
    logic push;      // accepted write adds one entry
    logic stallReq;  // write arrived with the queue full
    logic drain;     // one drain period has elapsed
  } fifoStrobe_t;
endpackage

// File: rtl/vid_status_ctrl.sv
module vid_status_ctrl
  import vid_status_pkg::*;
#(
  parameter int PERIOD_WIDE   = 190,
  parameter int PERIOD_NARROW = 214
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dataWr,
  input  logic        dispEnable,
  input  logic        vblank,
  input  logic        wideMode,
  input  logic        vramTarget,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  input  logic        stallPend,
  output fifoStrobe_t strobe
);
  localparam int PMAX = 2 * ((PERIOD_WIDE > PERIOD_NARROW) ? PERIOD_WIDE : PERIOD_NARROW);
  localparam int TW   = $clog2(PMAX + 1);

  logic [TW-1:0] drainTimer;
  logic [TW-1:0] basePeriod;
  logic [TW-1:0] period;
  logic          active;
  logic          drainNow;

  always_comb begin
    basePeriod = wideMode ? TW'(PERIOD_WIDE) : TW'(PERIOD_NARROW);
    period     = vramTarget ? (basePeriod << 1) : basePeriod;
    active     = dispEnable && !vblank;
    drainNow   = !fifoEmpty && (drainTimer >= period - TW'(1));
    strobe.drain    = drainNow;
    strobe.push     = dataWr && active && !stallPend && (!fifoFull || drainNow);
    strobe.stallReq = dataWr && active && !stallPend && fifoFull && !drainNow;
  end

  // timer is only cleared when empty or at a drain, never by a write
  always_ff @(posedge clk) begin
    if (!rst_n)         drainTimer <= '0;
    else if (fifoEmpty) drainTimer <= '0;
    else if (drainNow)  drainTimer <= '0;
    else                drainTimer <= drainTimer + TW'(1);
  end
endmodule

// File: rtl/vid_status_dp.sv
module vid_status_dp
  import vid_status_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LINE_CYCLES = 3420,
  parameter int HBLANK_END  = 588,
  localparam int LW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifoStrobe_t   strobe,
  input  logic          palMode,
  input  logic          dmaBusy,
  input  logic          oddField,
  input  logic          vintPending,
  input  logic          dispEnable,
  input  logic          vblank,
  input  logic [LW-1:0] linePos,
  input  logic          sprCollision,
  input  logic          sprOverflow,
  input  logic          statusRd,
  output logic [15:0]   statusWord,
  output logic          fifoFull,
  output logic          fifoEmpty,
  output logic          stallPend
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occupancy;
  logic          hitFlag;
  logic          overFlag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupancy <= '0;
      stallPend <= 1'b0;
    end else begin
      if (strobe.drain) begin
        if (stallPend)        stallPend <= 1'b0;
        else if (!strobe.push) occupancy <= occupancy - CW'(1);
      end else if (strobe.push) begin
        occupancy <= occupancy + CW'(1);
      end
      if (strobe.stallReq) stallPend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitFlag  <= 1'b0;
      overFlag <= 1'b0;
    end else begin
      hitFlag  <= sprCollision || (hitFlag && !statusRd);
      overFlag <= sprOverflow  || (overFlag && !statusRd);
    end
  end

  always_comb begin
    fifoFull   = (occupancy == CW'(DEPTH));
    fifoEmpty  = (occupancy == '0);
    statusWord = '0;
    statusWord[0] = palMode;
    statusWord[1] = dmaBusy;
    statusWord[2] = (linePos < LW'(HBLANK_END));
    statusWord[3] = vblank || !dispEnable;
    statusWord[4] = oddField;
    statusWord[5] = hitFlag;
    statusWord[6] = overFlag;
    statusWord[7] = vintPending;
    statusWord[8] = fifoFull;
    statusWord[9] = fifoEmpty;
  end
endmodule

// File: rtl/vid_status_fifo.sv
module vid_status_fifo
  import vid_status_pkg::*;
#(
  parameter int DEPTH         = 4,
  parameter int PERIOD_WIDE   = 190,
  parameter int PERIOD_NARROW = 214,
  parameter int LINE_CYCLES   = 3420,
  parameter int HBLANK_END    = 588,
  localparam int LW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          palMode,
  input  logic          dmaBusy,
  input  logic          oddField,
  input  logic          vintPending,
  input  logic          dispEnable,
  input  logic          vblank,
  input  logic          wideMode,
  input  logic          vramTarget,
  input  logic [LW-1:0] linePos,
  input  logic          sprCollision,
  input  logic          sprOverflow,
  input  logic          dataWr,
  input  logic          statusRd,
  output logic [15:0]   statusWord,
  output logic          fifoFull,
  output logic          fifoEmpty,
  output logic          cpuStall
);
  fifoStrobe_t strobe;
  logic        stallPend;

  vid_status_ctrl #(
    .PERIOD_WIDE(PERIOD_WIDE), .PERIOD_NARROW(PERIOD_NARROW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .dispEnable(dispEnable),
    .vblank(vblank), .wideMode(wideMode), .vramTarget(vramTarget),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .stallPend(stallPend),
    .strobe(strobe)
  );

  vid_status_dp #(
    .DEPTH(DEPTH), .LINE_CYCLES(LINE_CYCLES), .HBLANK_END(HBLANK_END)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .palMode(palMode),
    .dmaBusy(dmaBusy), .oddField(oddField), .vintPending(vintPending),
    .dispEnable(dispEnable), .vblank(vblank), .linePos(linePos),
    .sprCollision(sprCollision), .sprOverflow(sprOverflow),
    .statusRd(statusRd), .statusWord(statusWord), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .stallPend(stallPend)
  );

  assign cpuStall = stallPend;
endmodule

// File: rtl/vid_status_fifo_chk.sv
module vid_status_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dispEnable,
  input logic        vblank,
  input logic        dataWr,
  input logic        statusRd,
  input logic        sprCollision,
  input logic [15:0] statusWord,
  input logic        fifoFull,
  input logic        fifoEmpty,
  input logic        cpuStall
);
  // R7
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifoFull) |-> $past(dataWr && dispEnable && !vblank));

  // R5
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifoEmpty) |-> $past(dataWr && dispEnable && !vblank));

  // R10
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuStall |-> fifoFull);

  // R10
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpuStall) |-> fifoFull);

  // R12
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && !sprCollision) |=> !statusWord[5]);
endmodule

bind vid_status_fifo vid_status_fifo_chk i_chk (
  .clk(clk), .rst_n(rst_n), .dispEnable(dispEnable), .vblank(vblank),
  .dataWr(dataWr), .statusRd(statusRd), .sprCollision(sprCollision),
  .statusWord(statusWord), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .cpuStall(cpuStall)
);

// File: tb/test_vid_status_fifo.sv
`timescale 1ns/100ps
module test_vid_status_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        palMode = 1'b1, dmaBusy = 1'b0, oddField = 1'b0, vintPending = 1'b0;
  logic        dispEnable = 1'b1, vblank = 1'b0, wideMode = 1'b1, vramTarget = 1'b0;
  logic [11:0] linePos = 12'd1000;
  logic        sprCollision = 1'b0, sprOverflow = 1'b0, dataWr = 1'b0, statusRd = 1'b0;
  logic [15:0] statusWord;
  logic        fifoFull, fifoEmpty, cpuStall;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vid_status_fifo i_vid_status_fifo (
    .clk(clk), .rst_n(rst_n), .palMode(palMode), .dmaBusy(dmaBusy),
    .oddField(oddField), .vintPending(vintPending), .dispEnable(dispEnable),
    .vblank(vblank), .wideMode(wideMode), .vramTarget(vramTarget),
    .linePos(linePos), .sprCollision(sprCollision), .sprOverflow(sprOverflow),
    .dataWr(dataWr), .statusRd(statusRd), .statusWord(statusWord),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .cpuStall(cpuStall)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic writeOnce();
    @(negedge clk) dataWr = 1'b1;
    @(negedge clk) dataWr = 1'b0;
  endtask

  task automatic waitEmpty();
    for (int i = 0; i < 2000 && !fifoEmpty; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 status", statusWord, 16'h0201);
    check("R1 flags", {13'd0, fifoFull, fifoEmpty, cpuStall}, 16'h0002);
  endtask

  task automatic test_fields();
    @(negedge clk);
    palMode = 1'b0; dmaBusy = 1'b1; oddField = 1'b1; vintPending = 1'b1;
    #1 check("R2 pass-through", statusWord, 16'h0292);
    palMode = 1'b1; dmaBusy = 1'b0; oddField = 1'b0; vintPending = 1'b0;
    linePos = 12'd587;
    #1 check("R3 hblank at 587", statusWord & 16'h0004, 16'h0004);
    linePos = 12'd588;
    #1 check("R3 hblank at 588", statusWord & 16'h0004, 16'h0000);
    linePos = 12'd1000; dispEnable = 1'b0;
    #1 check("R4 display off", statusWord & 16'h0008, 16'h0008);
    dispEnable = 1'b1; vblank = 1'b1;
    #1 check("R4 vblank", statusWord & 16'h0008, 16'h0008);
    vblank = 1'b0;
    #1 check("R4 active", statusWord & 16'h0008, 16'h0000);
  endtask

  task automatic test_inactive();
    waitEmpty();
    vblank = 1'b1;
    for (int i = 0; i < 5; i++) writeOnce();
    check("R6 vblank writes", {15'd0, fifoEmpty}, 16'd1);
    vblank = 1'b0; dispEnable = 1'b0;
    writeOnce();
    check("R6 display-off write", statusWord & 16'h0200, 16'h0200);
    dispEnable = 1'b1;
  endtask

  task automatic test_drain(input logic wide, input logic vram, input int period);
    waitEmpty();
    wideMode = wide; vramTarget = vram;
    writeOnce();
    check("R5 empty cleared", statusWord & 16'h0200, 16'h0000);
    repeat (period - 1) @(negedge clk);
    check("R8 before drain", {15'd0, fifoEmpty}, 16'd0);
    @(negedge clk);
    check("R8 drained on time", {15'd0, fifoEmpty}, 16'd1);
  endtask

  task automatic test_full_stall();
    waitEmpty();
    wideMode = 1'b1; vramTarget = 1'b0;
    @(negedge clk) dataWr = 1'b1;
    repeat (5) @(negedge clk);
    dataWr = 1'b0;
    check("R7 full flags", {statusWord[8], fifoFull}, 16'h0003);
    check("R10 stall raised", {15'd0, cpuStall}, 16'd1);
    repeat (190 - 5) @(negedge clk);
    check("R10 stall held", {15'd0, cpuStall}, 16'd1);
    @(negedge clk);
    check("R10 stall released", {15'd0, cpuStall}, 16'd0);
    check("R10 still full", {15'd0, fifoFull}, 16'd1);
    repeat (190 - 1) @(negedge clk);
    check("R9 full before drain", {15'd0, fifoFull}, 16'd1);
    @(negedge clk);
    check("R9 full cleared", {14'd0, fifoFull, fifoEmpty}, 16'd0);
  endtask

  task automatic test_carry();
    waitEmpty();
    wideMode = 1'b0; vramTarget = 1'b0;
    writeOnce();
    repeat (99) @(negedge clk);
    dataWr = 1'b1;
    @(negedge clk) dataWr = 1'b0;
    repeat (327) @(negedge clk);
    check("R11 not yet empty", {15'd0, fifoEmpty}, 16'd0);
    @(negedge clk);
    check("R11 empty at two periods", {15'd0, fifoEmpty}, 16'd1);
  endtask

  task automatic test_sticky();
    @(negedge clk) sprCollision = 1'b1; sprOverflow = 1'b1;
    @(negedge clk) sprCollision = 1'b0; sprOverflow = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 held", statusWord & 16'h0060, 16'h0060);
    statusRd = 1'b1;
    #1 check("R12 visible in read", statusWord & 16'h0060, 16'h0060);
    @(negedge clk) statusRd = 1'b0;
    check("R12 cleared after read", statusWord & 16'h0060, 16'h0000);
    statusRd = 1'b1; sprCollision = 1'b1;
    @(negedge clk) statusRd = 1'b0; sprCollision = 1'b0;
    check("R12 event wins over read", statusWord & 16'h0060, 16'h0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_fields();
    test_inactive();
    test_drain(1'b1, 1'b0, 190);
    test_drain(1'b0, 1'b0, 214);
    test_drain(1'b1, 1'b1, 380);
    test_drain(1'b0, 1'b1, 428);
    test_full_stall();
    test_carry();
    test_sticky();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule